// File: doc/BRIEF.md
# Cascadable Dual-Strobe Up/Down Counter Stage

This block is a small counter stage. Its count is advanced by two separate strobe inputs. A rising edge on the up strobe adds one to the count, and a rising edge on the down strobe subtracts one. The strobe that is not in use rests high. Both strobes are asynchronous to the system clock. Each one passes through a two-flop synchronizer and is edge-detected, so the count register, the preset path and the clear all run on the single system clock. The only exception is the clear, which acts immediately.

A parameter picks the sequence. Binary mode steps through 0 to 15. Decimal mode steps through 0 to 9. The count can also be preset from a data bus while an active-low load input is held low. A high on the clear input forces the count to zero and takes priority over every other input.

Two active-low outputs, carry and borrow, are formed from the strobe levels and the count. Carry is low while the up strobe is low and the count sits at its top value. Borrow is low while the down strobe is low and the count is zero. Each returns high as its strobe rises, so that rising edge can drive the next stage directly. To chain stages, connect a stage's carry to the next stage's up strobe and its borrow to the next stage's down strobe, with no gating in between. The block has no data stream, so every pin is a plain control or status signal and there is no valid/ready handshake.

Top module: `updn_stage`

## Requirements
- R1: While `clr` is 1 the count is 0, without waiting for a clock edge. Clear overrides load, preset data and both strobes. After clear is released, strobes that are resting high cause no count.
- R2: With `clr` at 0 and `preset_n` at 0, each clock edge copies `pdata` into the count. Strobe edges that arrive during this time have no effect.
- R3: Suppose the up strobe rises while the down strobe rests high. The count then increases by one on the third rising clock edge after the change (two synchronizer flops, then the count register).
- R4: A rise of the down strobe while the up strobe rests high decreases the count by one, with the same latency as R3.
- R5: In binary mode (`DECIMAL`=0), counting up wraps from 15 to 0 and counting down wraps from 0 to 15.
- R6: In decimal mode (`DECIMAL`=1), counting up wraps from 9 to 0 and counting down wraps from 0 to 9.
- R7: `carry_n` is 0 exactly when the synchronized up level is 0 and the count equals the top value (15 in binary mode, 9 in decimal mode). Otherwise it is 1.
- R8: `borrow_n` is 0 exactly when the synchronized down level is 0 and the count is 0. Otherwise it is 1.
- R9: If rising edges on both strobes are seen in the same clock cycle, the count does not change.
- R10: In decimal mode, an up step from any value in 10..15 gives 0, and a down step from a value in 10..15 gives that value minus one.
- R11: When stages are chained carry-to-up and borrow-to-down, the upper stage increments when the lower one wraps upward and decrements when the lower one wraps downward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| clr | input | 1 | Active-high asynchronous clear |
| up_in | input | 1 | Up strobe; its rising edge counts up; rests high |
| dn_in | input | 1 | Down strobe; its rising edge counts down; rests high |
| preset_n | input | 1 | Active-low synchronous preset enable |
| pdata | input | WIDTH (4) | Preset value |
| cnt | output | WIDTH (4) | Current count |
| carry_n | output | 1 | Active-low carry, feeds the next stage's up strobe |
| borrow_n | output | 1 | Active-low borrow, feeds the next stage's down strobe |

## Verification
The strobes are tried in several patterns: single up pulses, single down pulses, pulses on both strobes at once, and pulses that arrive while a preset is held. Together these separate a correct step from a dropped step, a double step and a step taken during load. A binary stage and a decimal stage receive the same stimulus, so the two wrap rules and the decimal recovery from out-of-range values are compared side by side. A second binary stage, fed only through the first stage's carry and borrow, shows whether the pulse shaping is correct at the terminal values. The carry and borrow levels are sampled while the strobe is low, which is when they can be active.

// File: rtl/updn_pkg.sv
package updn_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_LOAD = 2'd1,
    STEP_INC  = 2'd2,
    STEP_DEC  = 2'd3
  } step_op_t;

  localparam int unsigned NUM_STROBES = 2;
  localparam int unsigned UP_IDX      = 0;
  localparam int unsigned DN_IDX      = 1;
endpackage

// File: rtl/updn_edge.sv
// Synchronizer plus rising-edge detector for one strobe. The chain resets
// high, so a strobe that rests high gives no edge when clear is released.
module updn_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic clr,
  input  logic din,
  output logic lvl,
  output logic rise
);
  localparam int unsigned LEN = STAGES + 1;

  logic [LEN-1:0] sh;

  always_ff @(posedge clk or posedge clr) begin
    if (clr) sh <= '1;
    else     sh <= {sh[LEN-2:0], din};
  end

  assign lvl  = sh[STAGES-1];
  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/updn_step.sv
// Next-count computation for one operation.
module updn_step
  import updn_pkg::*;
#(
  parameter int unsigned WIDTH   = 4,
  parameter bit          DECIMAL = 1'b0
) (
  input  step_op_t         op,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] pdata,
  output logic [WIDTH-1:0] nxt
);
  localparam logic [WIDTH-1:0] TOP = DECIMAL ? WIDTH'(9) : {WIDTH{1'b1}};

  always_comb begin
    unique case (op)
      STEP_LOAD: nxt = pdata;
      STEP_INC:  nxt = (cur >= TOP) ? '0 : cur + 1'b1;
      STEP_DEC:  nxt = (cur == '0) ? TOP : cur - 1'b1;
      default:   nxt = cur;
    endcase
  end
endmodule

// File: rtl/updn_term.sv
// Active-low carry and borrow, built from the synchronized strobe levels
// and the registered count.
module updn_term #(
  parameter int unsigned WIDTH   = 4,
  parameter bit          DECIMAL = 1'b0
) (
  input  logic [WIDTH-1:0] cnt,
  input  logic             up_lvl,
  input  logic             dn_lvl,
  output logic             carry_n,
  output logic             borrow_n
);
  localparam logic [WIDTH-1:0] TOP = DECIMAL ? WIDTH'(9) : {WIDTH{1'b1}};

  logic at_top, at_zero;

  assign at_top   = (cnt == TOP);
  assign at_zero  = (cnt == '0);
  assign carry_n  = ~(~up_lvl & at_top);
  assign borrow_n = ~(~dn_lvl & at_zero);
endmodule

// File: rtl/updn_stage.sv
module updn_stage
  import updn_pkg::*;
#(
  parameter int unsigned WIDTH       = 4,
  parameter bit          DECIMAL     = 1'b0,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             up_in,
  input  logic             dn_in,
  input  logic             preset_n,
  input  logic [WIDTH-1:0] pdata,
  output logic [WIDTH-1:0] cnt,
  output logic             carry_n,
  output logic             borrow_n
);
  logic [NUM_STROBES-1:0] strobe_raw, strobe_lvl, strobe_rise;
  logic up_lvl, dn_lvl, up_rise, dn_rise;
  step_op_t         op;
  logic [WIDTH-1:0] cnt_q, cnt_nxt;

  assign strobe_raw[UP_IDX] = up_in;
  assign strobe_raw[DN_IDX] = dn_in;

  for (genvar g = 0; g < NUM_STROBES; g++) begin : g_strobe
    updn_edge #(.STAGES(SYNC_STAGES)) edge_i (
      .clk (clk),
      .clr (clr),
      .din (strobe_raw[g]),
      .lvl (strobe_lvl[g]),
      .rise(strobe_rise[g])
    );
  end

  assign up_lvl  = strobe_lvl[UP_IDX];
  assign dn_lvl  = strobe_lvl[DN_IDX];
  assign up_rise = strobe_rise[UP_IDX];
  assign dn_rise = strobe_rise[DN_IDX];

  // Priority: preset, then a single-strobe step; coincident edges cancel.
  always_comb begin
    if (!preset_n)               op = STEP_LOAD;
    else if (up_rise && !dn_rise) op = STEP_INC;
    else if (dn_rise && !up_rise) op = STEP_DEC;
    else                          op = STEP_HOLD;
  end

  updn_step #(.WIDTH(WIDTH), .DECIMAL(DECIMAL)) step_i (
    .op   (op),
    .cur  (cnt_q),
    .pdata(pdata),
    .nxt  (cnt_nxt)
  );

  always_ff @(posedge clk or posedge clr) begin
    if (clr) cnt_q <= '0;
    else     cnt_q <= cnt_nxt;
  end

  assign cnt = cnt_q;

  updn_term #(.WIDTH(WIDTH), .DECIMAL(DECIMAL)) term_i (
    .cnt     (cnt_q),
    .up_lvl  (up_lvl),
    .dn_lvl  (dn_lvl),
    .carry_n (carry_n),
    .borrow_n(borrow_n)
  );
endmodule

// File: rtl/updn_stage_chk.sv
module updn_stage_chk #(
  parameter int unsigned WIDTH   = 4,
  parameter bit          DECIMAL = 1'b0
) (
  input logic             clk,
  input logic             clr,
  input logic             preset_n,
  input logic [WIDTH-1:0] pdata,
  input logic [WIDTH-1:0] cnt,
  input logic             carry_n,
  input logic             borrow_n,
  input logic             up_lvl,
  input logic             dn_lvl,
  input logic             up_rise,
  input logic             dn_rise
);
  localparam logic [WIDTH-1:0] TOP = DECIMAL ? WIDTH'(9) : {WIDTH{1'b1}};

  // R1
  clear_zero_chk: assert property (@(posedge clk) clr |-> (cnt == '0));

  // R2
  preset_copy_chk: assert property (@(posedge clk) disable iff (clr)
    !preset_n |=> (cnt == $past(pdata)));

  // R3
  up_step_chk: assert property (@(posedge clk) disable iff (clr)
    (preset_n && up_rise && !dn_rise) |=>
      ((cnt == WIDTH'($past(cnt) + 1'b1)) || (cnt == '0)));

  // R4
  down_step_chk: assert property (@(posedge clk) disable iff (clr)
    (preset_n && dn_rise && !up_rise) |=>
      ((cnt == WIDTH'($past(cnt) - 1'b1)) || (($past(cnt) == '0) && (cnt == TOP))));

  // R9
  both_hold_chk: assert property (@(posedge clk) disable iff (clr)
    (preset_n && up_rise && dn_rise) |=> $stable(cnt));

  // R7
  carry_when_chk: assert property (@(posedge clk) disable iff (clr)
    !carry_n |-> ((cnt == TOP) && !up_lvl));

  // R8
  borrow_when_chk: assert property (@(posedge clk) disable iff (clr)
    !borrow_n |-> ((cnt == '0) && !dn_lvl));

  // R10
  up_range_chk: assert property (@(posedge clk) disable iff (clr)
    (preset_n && up_rise && !dn_rise) |=> (cnt <= TOP));
endmodule

bind updn_stage updn_stage_chk #(.WIDTH(WIDTH), .DECIMAL(DECIMAL)) chk_i (
  .clk     (clk),
  .clr     (clr),
  .preset_n(preset_n),
  .pdata   (pdata),
  .cnt     (cnt),
  .carry_n (carry_n),
  .borrow_n(borrow_n),
  .up_lvl  (up_lvl),
  .dn_lvl  (dn_lvl),
  .up_rise (up_rise),
  .dn_rise (dn_rise)
);

// File: tb/updn_stage_tb_top.sv
module updn_stage_tb_top;
  logic clk = 1'b0;
  logic clr = 1'b1;
  logic inc_in = 1'b1, dec_in = 1'b1, preset_n = 1'b1;
  logic [3:0] pdata = 4'd0;
  logic [3:0] cnt_b, cnt_d, cnt_h;
  logic carry_b, borrow_b, carry_d, borrow_d, carry_h, borrow_h;

  int vectors = 0, fails = 0, cyc = 0;
  int exp_b = 0, exp_d = 0, exp_h = 0;

  always #4 clk = ~clk;

  updn_stage #(.WIDTH(4), .DECIMAL(1'b0)) dut_i (
    .clk(clk), .clr(clr), .up_in(inc_in), .dn_in(dec_in), .preset_n(preset_n),
    .pdata(pdata), .cnt(cnt_b), .carry_n(carry_b), .borrow_n(borrow_b));

  updn_stage #(.WIDTH(4), .DECIMAL(1'b1)) dut_dec (
    .clk(clk), .clr(clr), .up_in(inc_in), .dn_in(dec_in), .preset_n(preset_n),
    .pdata(pdata), .cnt(cnt_d), .carry_n(carry_d), .borrow_n(borrow_d));

  // Upper stage, fed only through dut_i's carry and borrow.
  updn_stage #(.WIDTH(4), .DECIMAL(1'b0)) dut_hi (
    .clk(clk), .clr(clr), .up_in(carry_b), .dn_in(borrow_b), .preset_n(1'b1),
    .pdata(4'd0), .cnt(cnt_h), .carry_n(carry_h), .borrow_n(borrow_h));

  function automatic int bin_up(int v); return (v + 1) % 16; endfunction
  function automatic int bin_dn(int v); return (v + 15) % 16; endfunction
  function automatic int dec_up(int v); return (v >= 9) ? 0 : v + 1; endfunction
  function automatic int dec_dn(int v); return (v == 0) ? 9 : v - 1; endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d at t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_counts(string tag_b, string tag_d);
    chk(tag_b, cnt_b, exp_b);
    chk(tag_d, cnt_d, exp_d);
    chk("R11 upper stage", cnt_h, exp_h);
  endtask

  task automatic up_pulse();
    inc_in = 1'b0;
    tick(4);
    chk("R7 carry binary", carry_b, (exp_b == 15) ? 0 : 1);
    chk("R7 carry decimal", carry_d, (exp_d == 9) ? 0 : 1);
    chk("R8 borrow idle", borrow_b, 1);
    inc_in = 1'b1;
    tick(8);
    if (exp_b == 15) exp_h = bin_up(exp_h);
    exp_b = bin_up(exp_b);
    exp_d = dec_up(exp_d);
    check_counts((exp_b == 0) ? "R5 up wrap" : "R3 up step",
                 (exp_d == 0) ? "R6/R10 decimal up" : "R3 decimal up");
  endtask

  task automatic down_pulse();
    int old_d = exp_d;
    dec_in = 1'b0;
    tick(4);
    chk("R8 borrow binary", borrow_b, (exp_b == 0) ? 0 : 1);
    chk("R8 borrow decimal", borrow_d, (exp_d == 0) ? 0 : 1);
    chk("R7 carry idle", carry_b, 1);
    dec_in = 1'b1;
    tick(8);
    if (exp_b == 0) exp_h = bin_dn(exp_h);
    exp_b = bin_dn(exp_b);
    exp_d = dec_dn(exp_d);
    check_counts((exp_b == 15) ? "R5 down wrap" : "R4 down step",
                 (old_d > 9) ? "R10 decimal down" :
                 (old_d == 0) ? "R6 decimal down wrap" : "R4 decimal down");
  endtask

  task automatic both_pulse();
    inc_in = 1'b0; dec_in = 1'b0;
    tick(4);
    inc_in = 1'b1; dec_in = 1'b1;
    tick(8);
    // The lower stage holds, but a terminal value still emits one shaped edge upward.
    if (exp_b == 15) exp_h = bin_up(exp_h);
    else if (exp_b == 0) exp_h = bin_dn(exp_h);
    check_counts("R9 both binary", "R9 both decimal");
  endtask

  task automatic load_op(int v, bit with_pulse);
    preset_n = 1'b0;
    pdata = 4'(v);
    tick(2);
    chk("R2 preset binary", cnt_b, v);
    chk("R2 preset decimal", cnt_d, v);
    if (with_pulse) begin
      inc_in = 1'b0;
      tick(4);
      inc_in = 1'b1;
      tick(6);
      if (v == 15) exp_h = bin_up(exp_h);
      chk("R2 strobe ignored binary", cnt_b, v);
      chk("R2 strobe ignored decimal", cnt_d, v);
    end
    preset_n = 1'b1;
    tick(6);
    exp_b = v;
    exp_d = v;
    check_counts("R2 after preset", "R2 after preset");
  endtask

  task automatic clear_op();
    clr = 1'b1;
    preset_n = 1'b0;
    pdata = 4'd5;
    #1;
    chk("R1 clear immediate binary", cnt_b, 0);
    chk("R1 clear immediate decimal", cnt_d, 0);
    tick(2);
    chk("R1 clear beats preset", cnt_b, 0);
    clr = 1'b0;
    preset_n = 1'b1;
    tick(6);
    exp_b = 0; exp_d = 0; exp_h = 0;
    check_counts("R1 after clear", "R1 after clear");
  endtask

  initial begin
    void'($urandom(32'd24681));
    tick(4);
    chk("R1 reset count", cnt_b, 0);
    chk("R7 reset carry", carry_b, 1);
    chk("R8 reset borrow", borrow_b, 1);
    clr = 1'b0;
    tick(6);
    check_counts("R1 no count after release", "R1 no count after release");

    // Directed corners.
    load_op(13, 1'b0);
    for (int i = 0; i < 5; i++) up_pulse();   // binary 14,15,0,1,2
    load_op(7, 1'b0);
    for (int i = 0; i < 3; i++) up_pulse();   // decimal 8,9,0
    load_op(1, 1'b0);
    for (int i = 0; i < 3; i++) down_pulse(); // 0, then 15 / 9
    load_op(15, 1'b1);
    both_pulse();
    load_op(12, 1'b0);
    for (int i = 0; i < 4; i++) up_pulse();   // decimal recovers from 12
    load_op(14, 1'b0);
    down_pulse();
    load_op(0, 1'b0);
    both_pulse();
    clear_op();

    // Constrained random mix.
    for (int n = 0; n < 300; n++) begin
      int sel = $urandom % 32;
      if (sel == 0) clear_op();
      else if (sel < 11) up_pulse();
      else if (sel < 21) down_pulse();
      else if (sel < 25) both_pulse();
      else load_op($urandom % 16, 1'($urandom % 2));
    end

    summary();
    $finish;
  end
endmodule